// File: doc/BRIEF.md
# Clock source switch controller

This block chooses which of three free-running oscillators clocks the system: an external primary oscillator, a low-power secondary oscillator and an internal RC oscillator. A 2-bit source select and a 3-bit primary-mode field set the target. Every switch is sequenced in the clock domain of the incoming oscillator. The new clock must first complete a warm-up count. For a crystal-type primary, a 1024-cycle start-up timer comes before that count. Until the warm-up ends, the system stays on the clock it already had.

The handover cannot glitch. Each source has a gate enable that is synchronised and updated only on that source's falling edge. The outgoing enable falls before the incoming one rises. Three flags report the state: the primary has finished its start-up and drives the system, the internal RC clock has been stable for a set time, and the secondary oscillator drives the system. After reset with a crystal primary, execution is held until the start-up count is done. An optional two-speed mode lets the internal RC clock run the system during that wait.

Top module: `osc_clk_switch`

## Requirements
- R1: Select decoding: 2'b00 targets the primary, 2'b01 the secondary, and 2'b10 or 2'b11 the internal RC clock. Primary modes 3'b000, 3'b001 and 3'b010 are crystal types. Every other mode value is a non-crystal (external clock or RC) primary.
- R2: A switch to the internal RC clock, the secondary or a non-crystal primary needs SETTLE_CYCLES cycles of the new clock (default 8) plus synchronisation before the handover. The old clock drives sys_clk_o until then.
- R3: A switch to a crystal primary counts OST_CYCLES (default 1024) plus SETTLE_CYCLES primary cycles before the handover. The previous clock keeps driving sys_clk_o for the whole count.
- R4: ost_done_o is 1 exactly while the primary drives the system and is 0 while the internal RC clock does.
- R5: sec_run_o is 1 exactly while the secondary oscillator drives the system.
- R6: irc_stable_o rises STAB_CYCLES internal RC cycles after the internal RC clock takes over. It is 0 whenever that clock does not drive the system.
- R7: A select of 2'b01 while sec_en_i is 0 is ignored. The current source and all flags stay unchanged.
- R8: After reset with a crystal primary and two_speed_i at 0, cur_src_o reads 2'b11 (no source) and sys_run_o stays 0 until the primary has counted its start-up and warm-up.
- R9: After reset with a crystal primary and two_speed_i at 1, the internal RC clock drives the system until the primary is ready. Then the primary takes over.
- R10: A new select that arrives while a switch is pending restarts the sequence toward the newest target. The output source does not change until that sequence completes.
- R11: At most one gate enable is high at any time. sys_clk_o follows the oscillator named by cur_src_o, encoded 2'b00 primary, 2'b01 secondary, 2'b10 internal RC, 2'b11 none.
- R12: sys_run_o rises on the first system clock edge after reset and stays 1 until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_pri_i | input | 1 | Primary oscillator |
| clk_sec_i | input | 1 | Secondary low-power oscillator |
| clk_irc_i | input | 1 | Internal RC oscillator |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_sel_i | input | 2 | Requested clock source |
| pri_mode_i | input | 3 | Primary oscillator type |
| sec_en_i | input | 1 | Permits switching to the secondary |
| two_speed_i | input | 1 | Run from internal RC during crystal start-up after reset |
| sys_clk_o | output | 1 | Gated, glitch-free system clock |
| sys_run_o | output | 1 | Execution released since reset |
| cur_src_o | output | 2 | Source currently driving sys_clk_o |
| ost_done_o | output | 1 | Primary started up and driving |
| irc_stable_o | output | 1 | Internal RC stable |
| sec_run_o | output | 1 | Secondary driving |

## Verification
Some properties are checked on every cycle. The gate enables stay mutually exclusive. The secondary can only become the target while its permit bit is set. The stable flag appears only after the internal RC gate was on. No gate opens without its lane having finished warm-up. sys_run_o never falls once it is set. Other behaviour needs the directed scenarios. These cover the length of the crystal start-up wait, the old clock continuing during it, and the system clock rate after each handover. They also cover restarting toward a newer request, the two-speed boot order and the stabilisation delay of the RC flag.

// File: rtl/osc_sw_pkg.sv
package osc_sw_pkg;
   localparam int unsigned N_SRC = 3;
   localparam logic [1:0] SRC_PRI  = 2'd0;
   localparam logic [1:0] SRC_SEC  = 2'd1;
   localparam logic [1:0] SRC_IRC  = 2'd2;
   localparam logic [1:0] SRC_NONE = 2'd3;
   localparam logic [2:0] PM_LP = 3'd0;
   localparam logic [2:0] PM_XT = 3'd1;
   localparam logic [2:0] PM_HS = 3'd2;

   function automatic logic mode_is_crystal(input logic [2:0] m);
      return (m == PM_LP) || (m == PM_XT) || (m == PM_HS);
   endfunction
endpackage

// File: rtl/osc_clk_lane.sv
module osc_clk_lane #(
   parameter int unsigned SETTLE_CYCLES = 8,
   parameter int unsigned OST_CYCLES    = 1024,
   parameter int unsigned SYNC_STAGES   = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic sel_i,
   input  logic long_warm_i,
   input  logic others_rdy_i,
   input  logic others_en_i,
   output logic rdy_o,
   output logic en_o
);
   localparam int unsigned CW = $clog2(OST_CYCLES + SETTLE_CYCLES + 1);
   localparam logic [CW-1:0] LIM_SHORT = CW'(SETTLE_CYCLES - 1);
   localparam logic [CW-1:0] LIM_LONG  = CW'(OST_CYCLES + SETTLE_CYCLES - 1);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("osc_clk_lane: SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] sel_sync;
   logic [CW-1:0]          cnt;
   logic [CW-1:0]          lim;
   logic                   en_arm;
   logic                   want;

   assign lim  = long_warm_i ? LIM_LONG : LIM_SHORT;
   assign want = (rdy_o | (en_o & ~others_rdy_i)) & ~others_en_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sel_sync <= '0;
         cnt      <= '0;
         rdy_o    <= 1'b0;
         en_arm   <= 1'b0;
      end else begin
         sel_sync <= {sel_sync[SYNC_STAGES-2:0], sel_i};
         en_arm   <= want;
         if (!sel_sync[SYNC_STAGES-1]) begin
            cnt   <= '0;
            rdy_o <= 1'b0;
         end else if (!rdy_o) begin
            if (cnt == lim) rdy_o <= 1'b1;
            else            cnt   <= cnt + 1'b1;
         end
      end
   end

   always_ff @(negedge clk_i or negedge rst_ni) begin
      if (!rst_ni) en_o <= 1'b0;
      else         en_o <= en_arm;
   end
endmodule

// File: rtl/osc_stab_timer.sv
module osc_stab_timer #(
   parameter int unsigned STAB_CYCLES = 125
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic run_i,
   output logic stable_o
);
   localparam int unsigned CW = $clog2(STAB_CYCLES + 1);
   localparam logic [CW-1:0] LIM = CW'(STAB_CYCLES - 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt      <= '0;
         stable_o <= 1'b0;
      end else if (!run_i) begin
         cnt      <= '0;
         stable_o <= 1'b0;
      end else if (!stable_o) begin
         if (cnt == LIM) stable_o <= 1'b1;
         else            cnt      <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/osc_clk_switch.sv
module osc_clk_switch
   import osc_sw_pkg::*;
#(
   parameter int unsigned SETTLE_CYCLES = 8,
   parameter int unsigned OST_CYCLES    = 1024,
   parameter int unsigned STAB_CYCLES   = 125,
   parameter int unsigned SYNC_STAGES   = 2
) (
   input  logic       clk_pri_i,
   input  logic       clk_sec_i,
   input  logic       clk_irc_i,
   input  logic       rst_ni,
   input  logic [1:0] src_sel_i,
   input  logic [2:0] pri_mode_i,
   input  logic       sec_en_i,
   input  logic       two_speed_i,
   output logic       sys_clk_o,
   output logic       sys_run_o,
   output logic [1:0] cur_src_o,
   output logic       ost_done_o,
   output logic       irc_stable_o,
   output logic       sec_run_o
);
   localparam logic [N_SRC-1:0] ONE = N_SRC'(1);

   if (SETTLE_CYCLES < 1) begin : g_bad_settle
      $error("osc_clk_switch: SETTLE_CYCLES must be positive");
   end
   if (OST_CYCLES < 1) begin : g_bad_ost
      $error("osc_clk_switch: OST_CYCLES must be positive");
   end
   if (STAB_CYCLES < 1) begin : g_bad_stab
      $error("osc_clk_switch: STAB_CYCLES must be positive");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("osc_clk_switch: SYNC_STAGES must be at least 2");
   end

   logic [1:0]             tgt_q;
   logic                   boot_q;
   logic [SYNC_STAGES-1:0] boot_sync;
   logic                   pri_crystal;
   logic [N_SRC-1:0]       clk_vec, lane_sel, lane_long, lane_rdy, lane_en;
   logic [N_SRC-1:0]       others_rdy, others_en;

   assign pri_crystal = mode_is_crystal(pri_mode_i);
   assign clk_vec     = {clk_irc_i, clk_sec_i, clk_pri_i};
   assign lane_long   = {1'b0, 1'b0, pri_crystal};

   // Target source, decoded in the always-running internal RC domain
   always_ff @(posedge clk_irc_i or negedge rst_ni) begin
      if (!rst_ni) tgt_q <= SRC_PRI;
      else begin
         case (src_sel_i)
            2'b00:   tgt_q <= SRC_PRI;
            2'b01:   if (sec_en_i) tgt_q <= SRC_SEC;
            default: tgt_q <= SRC_IRC;
         endcase
      end
   end

   // Boot phase lasts until the primary first completes its warm-up
   always_ff @(posedge clk_pri_i or negedge rst_ni) begin
      if (!rst_ni)              boot_q <= 1'b1;
      else if (lane_rdy[SRC_PRI]) boot_q <= 1'b0;
   end

   always_ff @(posedge clk_irc_i or negedge rst_ni) begin
      if (!rst_ni) boot_sync <= '1;
      else         boot_sync <= {boot_sync[SYNC_STAGES-2:0], boot_q};
   end

   assign lane_sel[SRC_PRI] = (tgt_q == SRC_PRI);
   assign lane_sel[SRC_SEC] = (tgt_q == SRC_SEC);
   assign lane_sel[SRC_IRC] = (tgt_q == SRC_IRC) |
                              ((tgt_q == SRC_PRI) & two_speed_i & pri_crystal &
                               boot_sync[SYNC_STAGES-1]);

   for (genvar i = 0; i < N_SRC; i++) begin : g_lane
      assign others_rdy[i] = |(lane_rdy & ~(ONE << i));
      assign others_en[i]  = |(lane_en  & ~(ONE << i));
      osc_clk_lane #(
         .SETTLE_CYCLES(SETTLE_CYCLES),
         .OST_CYCLES   (OST_CYCLES),
         .SYNC_STAGES  (SYNC_STAGES)
      ) u_lane (
         .clk_i       (clk_vec[i]),
         .rst_ni      (rst_ni),
         .sel_i       (lane_sel[i]),
         .long_warm_i (lane_long[i]),
         .others_rdy_i(others_rdy[i]),
         .others_en_i (others_en[i]),
         .rdy_o       (lane_rdy[i]),
         .en_o        (lane_en[i])
      );
   end

   osc_stab_timer #(.STAB_CYCLES(STAB_CYCLES)) u_stab (
      .clk_i   (clk_irc_i),
      .rst_ni  (rst_ni),
      .run_i   (lane_en[SRC_IRC]),
      .stable_o(irc_stable_o)
   );

   assign sys_clk_o = |(clk_vec & lane_en);

   always_comb begin
      cur_src_o = SRC_NONE;
      for (int k = 0; k < N_SRC; k++) begin
         if (lane_en[k]) cur_src_o = 2'(k);
      end
   end

   always_ff @(posedge sys_clk_o or negedge rst_ni) begin
      if (!rst_ni) sys_run_o <= 1'b0;
      else         sys_run_o <= 1'b1;
   end

   assign ost_done_o = lane_en[SRC_PRI];
   assign sec_run_o  = lane_en[SRC_SEC];
endmodule

// File: rtl/osc_clk_switch_chk.sv
module osc_clk_switch_chk
   import osc_sw_pkg::*;
(
   input logic             clk_irc_i,
   input logic             clk_pri_i,
   input logic             rst_ni,
   input logic [1:0]       tgt_q,
   input logic             sec_en_i,
   input logic [N_SRC-1:0] lane_en,
   input logic [N_SRC-1:0] lane_rdy,
   input logic             irc_stable_o,
   input logic             sys_run_o
);
   AST_ONE_GATE_OPEN: assert property (@(posedge clk_irc_i) disable iff (!rst_ni)
      $onehot0(lane_en)); // R11

   AST_SEC_NEEDS_PERMIT: assert property (@(posedge clk_irc_i) disable iff (!rst_ni)
      (tgt_q == SRC_SEC && $past(tgt_q) != SRC_SEC) |-> $past(sec_en_i)); // R7

   AST_STABLE_NEEDS_IRC: assert property (@(posedge clk_irc_i) disable iff (!rst_ni)
      irc_stable_o |-> $past(lane_en[SRC_IRC])); // R6

   AST_RUN_NEVER_FALLS: assert property (@(posedge clk_irc_i) disable iff (!rst_ni)
      !$fell(sys_run_o)); // R12

   AST_PRI_GATE_AFTER_WARM: assert property (@(posedge clk_pri_i) disable iff (!rst_ni)
      $rose(lane_en[SRC_PRI]) |-> $past(lane_rdy[SRC_PRI])); // R3

   AST_IRC_GATE_AFTER_WARM: assert property (@(posedge clk_irc_i) disable iff (!rst_ni)
      $rose(lane_en[SRC_IRC]) |-> $past(lane_rdy[SRC_IRC])); // R2
endmodule

bind osc_clk_switch osc_clk_switch_chk u_chk (
   .clk_irc_i   (clk_irc_i),
   .clk_pri_i   (clk_pri_i),
   .rst_ni      (rst_ni),
   .tgt_q       (tgt_q),
   .sec_en_i    (sec_en_i),
   .lane_en     (lane_en),
   .lane_rdy    (lane_rdy),
   .irc_stable_o(irc_stable_o),
   .sys_run_o   (sys_run_o)
);

// File: tb/osc_clk_switch_bench.sv
module osc_clk_switch_bench;
   localparam int CLK_PERIOD = 20;   // internal RC clock, the bench timebase
   localparam int PRI_PERIOD = 8;
   localparam int SEC_PERIOD = 52;
   localparam int STAB       = 50;

   logic       clk_pri = 1'b0, clk_sec = 1'b0, clk_irc = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] src_sel = 2'b00;
   logic [2:0] pri_mode = 3'b001;
   logic       sec_en = 1'b0, two_speed = 1'b0;
   logic       sys_clk, sys_run, ost_done, irc_stable, sec_run;
   logic [1:0] cur_src;

   int n_checks = 0;
   int n_fail   = 0;
   int edges    = 0;
   bit done     = 1'b0;

   always #(CLK_PERIOD/2) clk_irc = ~clk_irc;
   always #(PRI_PERIOD/2) clk_pri = ~clk_pri;
   always #(SEC_PERIOD/2) clk_sec = ~clk_sec;
   always @(posedge sys_clk) edges++;

   osc_clk_switch #(.STAB_CYCLES(STAB)) u_osc_clk_switch (
      .clk_pri_i(clk_pri), .clk_sec_i(clk_sec), .clk_irc_i(clk_irc),
      .rst_ni(rst_n), .src_sel_i(src_sel), .pri_mode_i(pri_mode),
      .sec_en_i(sec_en), .two_speed_i(two_speed),
      .sys_clk_o(sys_clk), .sys_run_o(sys_run), .cur_src_o(cur_src),
      .ost_done_o(ost_done), .irc_stable_o(irc_stable), .sec_run_o(sec_run)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // advance n internal RC cycles, sampling 1 time unit after the rising edge
   task automatic tick(input int n);
      repeat (n) @(posedge clk_irc);
      #1;
   endtask

   task automatic wait_src(input logic [1:0] exp, input int limit, output int took);
      took = -1;
      for (int c = 0; c < limit; c++) begin
         if (cur_src == exp) begin
            took = c;
            break;
         end
         tick(1);
      end
   endtask

   task automatic freq_check(input string req, input int exp);
      int c0, d;
      c0 = edges;
      #(CLK_PERIOD*26);
      d = edges - c0;
      check(d >= exp - 1 && d <= exp + 1, req, "sys_clk edge count", d, exp);
   endtask

   task automatic do_reset(input bit ts, input logic [2:0] mode);
      rst_n = 1'b0; two_speed = ts; pri_mode = mode; src_sel = 2'b00; sec_en = 1'b0;
      tick(3);
      check(sys_run == 1'b0, "R12", "sys_run in reset", int'(sys_run), 0);
      check(cur_src == 2'b11, "R11", "cur_src in reset", int'(cur_src), 3);
      check(ost_done == 1'b0 && irc_stable == 1'b0 && sec_run == 1'b0, "R4",
            "flags in reset", int'({ost_done, irc_stable, sec_run}), 0);
      rst_n = 1'b1;
   endtask

   task automatic t_boot_crystal();
      int took;
      do_reset(1'b0, 3'b001);
      tick(390);
      check(sys_run == 1'b0, "R8", "run held during start-up", int'(sys_run), 0);
      check(cur_src == 2'b11, "R8", "no source during start-up", int'(cur_src), 3);
      wait_src(2'b00, 80, took);
      check(took >= 0, "R8", "primary after start-up", int'(cur_src), 0);
      check(ost_done == 1'b1, "R4", "ost_done on primary", int'(ost_done), 1);
      tick(2);
      check(sys_run == 1'b1, "R12", "run released", int'(sys_run), 1);
      freq_check("R11", 65);
   endtask

   task automatic t_to_irc();
      int took;
      src_sel = 2'b10;
      tick(4);
      check(cur_src == 2'b00, "R2", "old clock during warm-up", int'(cur_src), 0);
      wait_src(2'b10, 40, took);
      check(took >= 0, "R1", "select 10 reaches internal RC", int'(cur_src), 2);
      check(ost_done == 1'b0, "R4", "ost_done under internal RC", int'(ost_done), 0);
      check(sec_run == 1'b0, "R5", "sec_run under internal RC", int'(sec_run), 0);
      check(irc_stable == 1'b0, "R6", "stable at handover", int'(irc_stable), 0);
      tick(STAB - 6);
      check(irc_stable == 1'b0, "R6", "stable before delay", int'(irc_stable), 0);
      tick(12);
      check(irc_stable == 1'b1, "R6", "stable after delay", int'(irc_stable), 1);
      freq_check("R11", 26);
   endtask

   task automatic t_sec_blocked();
      sec_en = 1'b0; src_sel = 2'b01;
      tick(60);
      check(cur_src == 2'b10, "R7", "source kept without permit", int'(cur_src), 2);
      check(sec_run == 1'b0, "R7", "sec_run without permit", int'(sec_run), 0);
      check(irc_stable == 1'b1, "R7", "stable flag untouched", int'(irc_stable), 1);
   endtask

   task automatic t_sec();
      int took;
      sec_en = 1'b1;
      wait_src(2'b01, 80, took);
      check(took >= 0, "R2", "secondary takes over", int'(cur_src), 1);
      check(sec_run == 1'b1, "R5", "sec_run on secondary", int'(sec_run), 1);
      check(ost_done == 1'b0, "R4", "ost_done on secondary", int'(ost_done), 0);
      tick(2);
      check(irc_stable == 1'b0, "R6", "stable cleared off RC", int'(irc_stable), 0);
      freq_check("R11", 10);
   endtask

   task automatic t_ec();
      int took;
      pri_mode = 3'b011; src_sel = 2'b00;
      wait_src(2'b00, 40, took);
      check(took >= 0, "R1", "non-crystal primary without start-up timer", int'(cur_src), 0);
      check(ost_done == 1'b1, "R4", "ost_done after external switch", int'(ost_done), 1);
      check(sec_run == 1'b0, "R5", "sec_run off secondary", int'(sec_run), 0);
   endtask

   task automatic t_xtal();
      int took;
      src_sel = 2'b11;
      wait_src(2'b10, 40, took);
      check(took >= 0, "R1", "select 11 reaches internal RC", int'(cur_src), 2);
      pri_mode = 3'b010; src_sel = 2'b00;
      tick(360);
      freq_check("R3", 26);
      check(cur_src == 2'b10, "R3", "old clock during start-up", int'(cur_src), 2);
      wait_src(2'b00, 100, took);
      check(took >= 0, "R3", "crystal primary after start-up", int'(cur_src), 0);
      check(ost_done == 1'b1, "R4", "ost_done after crystal switch", int'(ost_done), 1);
   endtask

   task automatic t_restart();
      int took;
      bit stayed = 1'b1;
      bit saw_sec = 1'b0;
      sec_en = 1'b1; src_sel = 2'b01;
      for (int c = 0; c < 6; c++) begin
         tick(1);
         if (cur_src != 2'b00) stayed = 1'b0;
      end
      check(stayed, "R10", "output kept while pending", int'(cur_src), 0);
      src_sel = 2'b10;
      took = -1;
      for (int c = 0; c < 60; c++) begin
         if (sec_run) saw_sec = 1'b1;
         if (cur_src == 2'b10) begin
            took = c;
            break;
         end
         tick(1);
      end
      check(took >= 0, "R10", "newest target reached", int'(cur_src), 2);
      check(!saw_sec, "R10", "abandoned target never driven", int'(saw_sec), 0);
      check(sys_run == 1'b1, "R12", "run stays high across switches", int'(sys_run), 1);
   endtask

   task automatic t_boot_two_speed();
      int took;
      do_reset(1'b1, 3'b000);
      wait_src(2'b10, 40, took);
      check(took >= 0, "R9", "internal RC during start-up", int'(cur_src), 2);
      tick(2);
      check(sys_run == 1'b1, "R9", "run released early", int'(sys_run), 1);
      check(ost_done == 1'b0, "R4", "ost_done during start-up", int'(ost_done), 0);
      tick(330);
      check(cur_src == 2'b10, "R9", "still internal RC", int'(cur_src), 2);
      wait_src(2'b00, 120, took);
      check(took >= 0, "R9", "primary takes over", int'(cur_src), 0);
      check(ost_done == 1'b1, "R4", "ost_done after boot", int'(ost_done), 1);
      freq_check("R11", 65);
   endtask

   initial begin
      #(CLK_PERIOD*100000);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual running expected finished");
         $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      t_boot_crystal();
      t_to_irc();
      t_sec_blocked();
      t_sec();
      t_ec();
      t_xtal();
      t_restart();
      t_boot_two_speed();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end
endmodule